// File: doc/BRIEF.md
# Paged PHY Management Register File

This block holds the management registers of a twelve-port PHY behind a parallel read/write access port, such as the one left after an MDIO frame has been deserialized. A strapped base selects the first of twelve consecutive port addresses, and the block claims those addresses modulo 32. Each claimed port sees a 32-entry window of 16-bit registers. The last entry of the window is a per-port page selector. Page zero holds the standard control, status and identifier registers, general storage, an indirect path into a small table of energy-efficiency MMD registers, and an auxiliary status register that reports the negotiated link state. Any other page replaces the whole of entries 0 to 30.

One vendor page holds a command mailbox. Only the first port of the device can reach it. A write that sets the start bit passes the command word to an external decoder through a one-cycle strobe. The start bit then reads back as busy until the decoder reports completion, and at that point the decoder's result takes the place of the stored word.

An access is presented for one cycle. A claimed access is acknowledged in the following cycle, and for a read the data appears in that same cycle.

Top module: `phymgmt_regfile`

## Requirements
- R1: A request is claimed when (phy address − strap base) mod 32 is below 12. A claimed request raises `mgmt_ack` for exactly the next cycle, and for a read `mgmt_rdata` carries the data in that cycle. An unclaimed request gets no acknowledge.
- R2: Register 31 holds a 16-bit page selector that can be read and written on every page. Each port has its own selector.
- R3: While a port's page is not 0x0000, registers 0–30 of that port read as zero and ignore writes, except for the mailbox named in R9. The page-zero contents are unchanged when page zero is selected again.
- R4: Register 0 reads back the last value written to it. Its reset value is 0x1140. It never reflects negotiated link state.
- R5: Register 1 reads the fixed status value 0x796D. Registers 2 and 3 read the identifier values 0x0007 and 0x06E0. Writes to all three are ignored.
- R6: Register 0x1C on page zero reads the port's auxiliary status input zero-extended. Bit 5 is MDI-X, bits 4:3 are speed, bit 2 is full duplex, bit 1 is pair swap and bit 0 is polarity inversion.
- R7: Register 13 stores a function field in bits 15:14 and a device number in bits 4:0. When the function is 00, register 14 reads and writes the stored MMD address. Any other function makes register 14 access the data at that device and address, and the address does not increment.
- R8: Each port holds five MMD data registers, at (device, address) = (3,1), (3,20), (3,22), (7,60) and (7,61), all reset to zero. Data accesses to any other location read zero and ignore writes.
- R9: The mailbox is register 0x12 of page 0x0010 on the first port only. On other ports that location reads zero.
- R10: A mailbox write with bit 15 set while idle raises `cmd_start` for one cycle, starting in the cycle after the write, with `cmd_word` equal to bits 14:0 of the write. The mailbox then reads bit 15 = 1 with the written low bits. A write with bit 15 clear only stores bits 14:0.
- R11: While the mailbox is busy, writes to it are ignored. On `cmd_done` the mailbox becomes idle and its bits 14:0 take the value of `cmd_result`.
- R12: After reset every page selector is 0x0000, the mailbox is idle with a zero word, and `mgmt_ack` and `cmd_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_base | input | 5 | Strapped first port address |
| mgmt_req | input | 1 | Access request, one cycle |
| mgmt_we | input | 1 | 1 = write, 0 = read |
| mgmt_phy | input | 5 | Port address of the access |
| mgmt_reg | input | 5 | Register address within the window |
| mgmt_wdata | input | 16 | Write data |
| mgmt_ack | output | 1 | Claimed access acknowledged |
| mgmt_rdata | output | 16 | Read data, valid with the acknowledge |
| port_aux | input | 72 | Per-port auxiliary status, 6 bits per port, port 0 lowest |
| cmd_start | output | 1 | Mailbox command strobe |
| cmd_word | output | 15 | Command word for the decoder |
| cmd_done | input | 1 | Decoder completion |
| cmd_result | input | 15 | Decoder result word |

## Verification
The bench moves the strap base so that the claimed range wraps past address 31. A design without modulo arithmetic would claim the wrong ports or none at all. It writes register 0 while a vendor page is selected and then returns to page zero, which catches a window that leaks writes through to the standard set. It walks the MMD path across two devices, one unmapped address and a second port, which exposes shared storage, ignored function fields or aliasing of addresses. It also writes the mailbox while a command is outstanding and reads it after completion, which shows a busy bit that fails to block a write or a result that is never captured.

// File: rtl/phymgmt_pkg.sv
// Shared constants, types and helpers of the paged management register file.
// Assumes a 16-bit register width and five MMD locations per port.
package phymgmt_pkg;

    localparam int MMD_N  = 5;
    localparam int AUX_W  = 6;

    typedef enum logic [1:0] {
        MMD_FN_ADDR   = 2'b00,
        MMD_FN_DATA   = 2'b01,
        MMD_FN_INC_RW = 2'b10,
        MMD_FN_INC_W  = 2'b11
    } mmd_fn_e;

    // Map (device, address) to a storage slot; MMD_N means unmapped.
    function automatic logic [2:0] mmd_slot(input logic [4:0] dev, input logic [15:0] addr);
        logic [2:0] s;
        s = 3'(MMD_N);
        if (dev == 5'd3 && addr == 16'd1)  s = 3'd0;
        if (dev == 5'd3 && addr == 16'd20) s = 3'd1;
        if (dev == 5'd3 && addr == 16'd22) s = 3'd2;
        if (dev == 5'd7 && addr == 16'd60) s = 3'd3;
        if (dev == 5'd7 && addr == 16'd61) s = 3'd4;
        return s;
    endfunction

    // Page-zero registers below 16 that hold written values.
    function automatic logic std_writable(input logic [3:0] idx);
        return !(idx == 4'd1 || idx == 4'd2 || idx == 4'd3 || idx == 4'd14);
    endfunction

endpackage

// File: rtl/phymgmt_port_regs.sv
// Register window of one port: page selector, page-zero standard and vendor
// registers, and indirect MMD storage. Assumes wr_en is already qualified by
// address decode; reads are combinational from current state.
module phymgmt_port_regs
    import phymgmt_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          RW       = 5,
    parameter logic [15:0] CTRL_RST = 16'h1140,
    parameter logic [15:0] STAT_RO  = 16'h796D,
    parameter logic [15:0] ID_HI    = 16'h0007,
    parameter logic [15:0] ID_LO    = 16'h06E0,
    parameter logic [4:0]  AUX_REG  = 5'h1C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RW-1:0]    reg_addr,
    input  logic [DW-1:0]    wdata,
    input  logic [AUX_W-1:0] aux,
    output logic [DW-1:0]    page_q,
    output logic [DW-1:0]    rd_data
);

    localparam logic [RW-1:0] PAGE_REG = RW'(31);
    localparam logic [RW-1:0] MMD_CTRL = RW'(13);
    localparam logic [RW-1:0] MMD_DATA = RW'(14);

    logic [DW-1:0] std_q [16];
    logic [DW-1:0] mmd_addr_q;
    logic [DW-1:0] mmd_q [MMD_N];
    mmd_fn_e       fn;
    logic [4:0]    dev;
    logic [2:0]    slot;
    logic          on_std;

    assign fn     = mmd_fn_e'(std_q[13][15:14]);
    assign dev    = std_q[13][4:0];
    assign slot   = mmd_slot(dev, mmd_addr_q);
    assign on_std = (page_q == '0) && (reg_addr < RW'(16));

    // State update for page selector, standard storage and MMD path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) std_q[i] <= '0;
            std_q[0]   <= CTRL_RST;
            page_q     <= '0;
            mmd_addr_q <= '0;
            for (int i = 0; i < MMD_N; i++) mmd_q[i] <= '0;
        end else if (wr_en) begin
            if (reg_addr == PAGE_REG) begin
                page_q <= wdata;
            end else if (on_std && reg_addr == MMD_DATA) begin
                if (fn == MMD_FN_ADDR)       mmd_addr_q <= wdata;
                else if (slot < 3'(MMD_N))  mmd_q[slot] <= wdata;
            end else if (on_std && std_writable(reg_addr[3:0])) begin
                std_q[reg_addr[3:0]] <= wdata;
            end
        end
    end

    // Read multiplexer for the current page.
    always_comb begin
        rd_data = '0;
        if (reg_addr == PAGE_REG) begin
            rd_data = page_q;
        end else if (page_q == '0) begin
            if (reg_addr == RW'(1))       rd_data = STAT_RO;
            else if (reg_addr == RW'(2))  rd_data = ID_HI;
            else if (reg_addr == RW'(3))  rd_data = ID_LO;
            else if (reg_addr == MMD_DATA) begin
                if (fn == MMD_FN_ADDR)      rd_data = mmd_addr_q;
                else if (slot < 3'(MMD_N)) rd_data = mmd_q[slot];
            end
            else if (reg_addr < RW'(16))  rd_data = std_q[reg_addr[3:0]];
            else if (reg_addr == AUX_REG) rd_data = DW'(aux);
        end
    end

    logic unused_ctrl;
    assign unused_ctrl = (MMD_CTRL == '0);

endmodule

// File: rtl/phymgmt_mailbox.sv
// Global command mailbox. Starts a command on a write with the top bit set
// while idle, holds busy until the decoder completes, then captures the result.
// Assumes wr_en is already qualified to the mailbox location.
module phymgmt_mailbox #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW:0]   wdata,
    input  logic          cmd_done,
    input  logic [CW-1:0] cmd_result,
    output logic          cmd_start,
    output logic [CW-1:0] cmd_word,
    output logic          busy,
    output logic [CW:0]   rd_data
);

    logic [CW-1:0] hold_q;

    // Command launch, busy tracking and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            hold_q    <= '0;
            cmd_start <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_start <= 1'b0;
            if (busy) begin
                if (cmd_done) begin
                    busy   <= 1'b0;
                    hold_q <= cmd_result;
                end
            end else if (wr_en) begin
                hold_q <= wdata[CW-1:0];
                if (wdata[CW]) begin
                    busy      <= 1'b1;
                    cmd_start <= 1'b1;
                    cmd_word  <= wdata[CW-1:0];
                end
            end
        end
    end

    assign rd_data = {busy, hold_q};

endmodule

// File: rtl/phymgmt_regfile.sv
// Top of the paged management register file: decodes the port address
// against the strap base, instantiates one register window per port, routes
// the global mailbox to the first port, and registers the response.
// Assumes single-cycle requests and a response in the following cycle.
module phymgmt_regfile
    import phymgmt_pkg::*;
#(
    parameter int          NPORT     = 12,
    parameter int          ADDR_W    = 5,
    parameter int          DW        = 16,
    parameter logic [15:0] MBOX_PAGE = 16'h0010,
    parameter logic [4:0]  MBOX_REG  = 5'h12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      strap_base,
    input  logic                   mgmt_req,
    input  logic                   mgmt_we,
    input  logic [ADDR_W-1:0]      mgmt_phy,
    input  logic [4:0]             mgmt_reg,
    input  logic [DW-1:0]          mgmt_wdata,
    output logic                   mgmt_ack,
    output logic [DW-1:0]          mgmt_rdata,
    input  logic [NPORT*AUX_W-1:0] port_aux,
    output logic                   cmd_start,
    output logic [DW-2:0]          cmd_word,
    input  logic                   cmd_done,
    input  logic [DW-2:0]          cmd_result
);

    logic [ADDR_W-1:0] idx;
    logic              claimed;
    logic              mbox_sel;
    logic              mbox_busy;
    logic [DW-1:0]     mbox_rd;
    logic [DW-1:0]     rd_arr   [NPORT];
    logic [DW-1:0]     page_arr [NPORT];
    logic [DW-1:0]     rd_sel;

    assign idx      = mgmt_phy - strap_base;
    assign claimed  = (idx < ADDR_W'(NPORT));
    assign mbox_sel = claimed && (idx == '0) && (page_arr[0] == MBOX_PAGE)
                      && (mgmt_reg == MBOX_REG);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        phymgmt_port_regs #(.DW(DW), .RW(5)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (mgmt_req && mgmt_we && claimed && idx == ADDR_W'(g)),
            .reg_addr (mgmt_reg),
            .wdata    (mgmt_wdata),
            .aux      (port_aux[g*AUX_W +: AUX_W]),
            .page_q   (page_arr[g]),
            .rd_data  (rd_arr[g])
        );
    end

    phymgmt_mailbox #(.CW(DW-1)) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mgmt_req && mgmt_we && mbox_sel),
        .wdata      (mgmt_wdata),
        .cmd_done   (cmd_done),
        .cmd_result (cmd_result),
        .cmd_start  (cmd_start),
        .cmd_word   (cmd_word),
        .busy       (mbox_busy),
        .rd_data    (mbox_rd)
    );

    // Select read data from the addressed port or the mailbox.
    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NPORT; i++)
            if (claimed && idx == ADDR_W'(i)) rd_sel = rd_arr[i];
        if (mbox_sel) rd_sel = mbox_rd;
    end

    // Register the acknowledge and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_ack   <= 1'b0;
            mgmt_rdata <= '0;
        end else begin
            mgmt_ack   <= mgmt_req && claimed;
            mgmt_rdata <= (mgmt_req && claimed && !mgmt_we) ? rd_sel : '0;
        end
    end

endmodule

// File: rtl/phymgmt_regfile_chk.sv
// Protocol checks for the register file, bound to the top module.
// Assumes the mailbox busy flag is visible as mbox_busy in the top.
module phymgmt_regfile_chk #(
    parameter int NPORT  = 12,
    parameter int ADDR_W = 5,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] strap_base,
    input logic              mgmt_req,
    input logic [ADDR_W-1:0] mgmt_phy,
    input logic              mgmt_ack,
    input logic              cmd_start,
    input logic [DW-2:0]     cmd_word,
    input logic              cmd_done,
    input logic              mbox_busy
);

    logic [ADDR_W-1:0] off;
    logic              in_range;
    assign off      = mgmt_phy - strap_base;
    assign in_range = (off < ADDR_W'(NPORT));

    // R1
    ack_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_ack |-> $past(mgmt_req && in_range));

    // R1
    unclaimed_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && !in_range) |=> !mgmt_ack);

    // R10
    busy_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mbox_busy) |-> cmd_start);

    // R10
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    // R11
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_busy && $past(mbox_busy)) |-> $stable(cmd_word));

    // R11
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mbox_busy) |-> $past(cmd_done));

endmodule

bind phymgmt_regfile phymgmt_regfile_chk #(.NPORT(NPORT), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_base (strap_base),
    .mgmt_req   (mgmt_req),
    .mgmt_phy   (mgmt_phy),
    .mgmt_ack   (mgmt_ack),
    .cmd_start  (cmd_start),
    .cmd_word   (cmd_word),
    .cmd_done   (cmd_done),
    .mbox_busy  (mbox_busy)
);

// File: tb/phymgmt_regfile_bench.sv
// Directed bench for the paged management register file.
module phymgmt_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_base = 5'd0;
    logic        mgmt_req = 1'b0;
    logic        mgmt_we = 1'b0;
    logic [4:0]  mgmt_phy = '0;
    logic [4:0]  mgmt_reg = '0;
    logic [15:0] mgmt_wdata = '0;
    logic        mgmt_ack;
    logic [15:0] mgmt_rdata;
    logic [NPORT*6-1:0] port_aux = '0;
    logic        cmd_start;
    logic [14:0] cmd_word;
    logic        cmd_done = 1'b0;
    logic [14:0] cmd_result = '0;

    int total = 0;
    int bad = 0;
    logic got_ack;
    logic [15:0] got_data;

    phymgmt_regfile u_phymgmt_regfile (
        .clk(clk), .rst_n(rst_n), .strap_base(strap_base),
        .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_phy(mgmt_phy),
        .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
        .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata), .port_aux(port_aux),
        .cmd_start(cmd_start), .cmd_word(cmd_word),
        .cmd_done(cmd_done), .cmd_result(cmd_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample response one cycle later.
    task automatic access(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wd);
        @(negedge clk);
        mgmt_req = 1'b1; mgmt_we = we; mgmt_phy = phy; mgmt_reg = rg; mgmt_wdata = wd;
        @(negedge clk);
        mgmt_req = 1'b0; mgmt_we = 1'b0;
        got_ack = mgmt_ack;
        got_data = mgmt_rdata;
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] rg);
        access(1'b0, phy, rg, 16'h0);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        access(1'b1, phy, rg, wd);
    endtask

    task automatic t_reset;
        check("R12 ack low", {15'b0, mgmt_ack}, 16'h0);
        check("R12 start low", {15'b0, cmd_start}, 16'h0);
        rd(5'd0, 5'd31);
        check("R12 page zero", got_data, 16'h0000);
        check("R1 ack on claimed read", {15'b0, got_ack}, 16'h1);
        rd(5'd11, 5'd0);
        check("R4 control reset", got_data, 16'h1140);
    endtask

    task automatic t_addr;
        rd(5'd12, 5'd2);
        check("R1 no ack above range", {15'b0, got_ack}, 16'h0);
        strap_base = 5'd24;
        rd(5'd3, 5'd2);
        check("R1 wrapped port claimed", {15'b0, got_ack}, 16'h1);
        check("R1 wrapped port data", got_data, 16'h0007);
        rd(5'd4, 5'd2);
        check("R1 past wrap not claimed", {15'b0, got_ack}, 16'h0);
        rd(5'd23, 5'd2);
        check("R1 below base not claimed", {15'b0, got_ack}, 16'h0);
        strap_base = 5'd0;
    endtask

    task automatic t_ctrl_ro;
        wr(5'd5, 5'd0, 16'h2100);
        rd(5'd5, 5'd0);
        check("R4 control last write", got_data, 16'h2100);
        rd(5'd6, 5'd0);
        check("R4 other port untouched", got_data, 16'h1140);
        wr(5'd5, 5'd2, 16'hFFFF);
        rd(5'd5, 5'd2);
        check("R5 id hi read-only", got_data, 16'h0007);
        rd(5'd5, 5'd3);
        check("R5 id lo", got_data, 16'h06E0);
        wr(5'd5, 5'd1, 16'h0000);
        rd(5'd5, 5'd1);
        check("R5 status read-only", got_data, 16'h796D);
    endtask

    task automatic t_page;
        wr(5'd3, 5'd31, 16'h0002);
        rd(5'd3, 5'd31);
        check("R2 page readback", got_data, 16'h0002);
        rd(5'd4, 5'd31);
        check("R2 page per port", got_data, 16'h0000);
        rd(5'd3, 5'd0);
        check("R3 std hidden", got_data, 16'h0000);
        wr(5'd3, 5'd0, 16'hAAAA);
        rd(5'd3, 5'd2);
        check("R3 id hidden", got_data, 16'h0000);
        wr(5'd3, 5'd31, 16'h0000);
        rd(5'd3, 5'd0);
        check("R3 write ignored on vendor page", got_data, 16'h1140);
    endtask

    task automatic t_aux;
        port_aux[7*6 +: 6] = 6'b101101;
        rd(5'd7, 5'h1C);
        check("R6 aux status", got_data, 16'h002D);
        wr(5'd7, 5'd31, 16'h0003);
        rd(5'd7, 5'h1C);
        check("R3 aux hidden", got_data, 16'h0000);
        wr(5'd7, 5'd31, 16'h0000);
    endtask

    task automatic t_mmd;
        wr(5'd2, 5'd13, 16'h0007);
        wr(5'd2, 5'd14, 16'h003C);
        rd(5'd2, 5'd14);
        check("R7 mmd address", got_data, 16'h003C);
        wr(5'd2, 5'd13, 16'h4007);
        wr(5'd2, 5'd14, 16'h1234);
        rd(5'd2, 5'd14);
        check("R8 mmd 7.60 data", got_data, 16'h1234);
        wr(5'd2, 5'd13, 16'h8007);
        rd(5'd2, 5'd14);
        check("R7 fn 10 no increment", got_data, 16'h1234);
        wr(5'd2, 5'd13, 16'h0007);
        rd(5'd2, 5'd14);
        check("R7 address unchanged", got_data, 16'h003C);
        wr(5'd2, 5'd13, 16'h0003);
        wr(5'd2, 5'd14, 16'd20);
        wr(5'd2, 5'd13, 16'h4003);
        wr(5'd2, 5'd14, 16'h5555);
        rd(5'd2, 5'd14);
        check("R8 mmd 3.20 data", got_data, 16'h5555);
        wr(5'd2, 5'd13, 16'h0003);
        wr(5'd2, 5'd14, 16'h0050);
        wr(5'd2, 5'd13, 16'h4003);
        wr(5'd2, 5'd14, 16'hBEEF);
        rd(5'd2, 5'd14);
        check("R8 unmapped reads zero", got_data, 16'h0000);
        wr(5'd2, 5'd13, 16'h0007);
        wr(5'd2, 5'd14, 16'h003C);
        wr(5'd2, 5'd13, 16'h4007);
        rd(5'd2, 5'd14);
        check("R8 7.60 kept", got_data, 16'h1234);
        wr(5'd9, 5'd13, 16'h0007);
        wr(5'd9, 5'd14, 16'h003C);
        wr(5'd9, 5'd13, 16'h4007);
        rd(5'd9, 5'd14);
        check("R8 per-port storage", got_data, 16'h0000);
    endtask

    task automatic t_mbox;
        wr(5'd1, 5'd31, 16'h0010);
        wr(5'd1, 5'h12, 16'h80A0);
        check("R9 other port no start", {15'b0, cmd_start}, 16'h0);
        rd(5'd1, 5'h12);
        check("R9 other port reads zero", got_data, 16'h0000);
        wr(5'd0, 5'd31, 16'h0010);
        wr(5'd0, 5'h12, 16'h0042);
        check("R10 no start without bit15", {15'b0, cmd_start}, 16'h0);
        rd(5'd0, 5'h12);
        check("R10 plain store", got_data, 16'h0042);
        wr(5'd0, 5'h12, 16'h80A0);
        check("R10 start pulse", {15'b0, cmd_start}, 16'h1);
        check("R10 command word", {1'b0, cmd_word}, 16'h00A0);
        rd(5'd0, 5'h12);
        check("R10 start one cycle", {15'b0, cmd_start}, 16'h0);
        check("R10 busy readback", got_data, 16'h80A0);
        wr(5'd0, 5'h12, 16'h8123);
        check("R11 no start while busy", {15'b0, cmd_start}, 16'h0);
        rd(5'd0, 5'h12);
        check("R11 write ignored while busy", got_data, 16'h80A0);
        @(negedge clk);
        cmd_done = 1'b1; cmd_result = 15'h0550;
        @(negedge clk);
        cmd_done = 1'b0;
        rd(5'd0, 5'h12);
        check("R11 result captured", got_data, 16'h0550);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_addr;
        t_ctrl_ro;
        t_page;
        t_aux;
        t_mmd;
        t_mbox;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule